// File: doc/BRIEF.md
# Transcoded Superblock Frame Assembler

This block builds a fixed-length GFP frame of 8800 octets from a stream of 513-bit transcoded blocks and presents it as 32-bit rows. Each superblock is 516 octets long. It holds eight input blocks back to back, followed by a short tail field that fills the superblock to its octet size. Seventeen superblocks fill the payload area of one frame.

Every frame opens with six rows. The first carries a core header word and the second a payload header word, both taken from input ports. The next four rows are reserved and are sent as zeros. Then come 2193 rows of superblock data, and one closing row of zeros brings the frame to 2200 rows. The header and reserved rows are sent back to back without waiting for input. Payload rows go out whenever the internal bit buffer holds at least one full row, and the next block is taken only once the buffer has fallen below one row.

The frame then wraps directly into the next frame's header.

Top module: `sgf_superblock_framer`

## Requirements
- R1: Every emitted row carries an index. Indices run 0, 1, …, 2199 in order without skipping, and wrap from 2199 back to 0.
- R2: `rowSof` is high on exactly those emitted rows whose index is 0, and low on every other cycle.
- R3: Row 0 carries the value on `coreHdr` and row 1 the value on `payHdr`, each sampled at the clock edge that registers the row.
- R4: Rows 2 to 5 carry all zeros.
- R5: Rows 6 to 2198 carry 17 superblocks of 129 rows each, in order. Each superblock is made of three parts, in this order:
  - eight accepted blocks in acceptance order, each packed from bit 512 down to bit 0;
  - the 24-bit tail field, most significant bit first;
  - nothing else.
  Bits are packed across row boundaries, and the first bit of a row lands in `rowData[31]`.
- R6: Row 2199 carries all zeros.
- R7: A block is accepted on a cycle where `blkValid` and `blkReady` are both high. `blkReady` is high only while payload rows are due, and then only when three conditions hold together:
  - fewer than 32 unsent bits are buffered;
  - fewer than 136 blocks have been taken in the current frame;
  - the next row to emit is a payload row.
- R8: A row is emitted (seen as `rowValid` high on the following cycle) on every cycle spent on header, reserved or closing rows, and on every payload cycle whose buffer holds at least 32 bits. No row is emitted in any other cycle.
- R9: While `rstN` is low, `rowValid`, `rowSof` and `blkReady` are low. The first row after reset is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| blkValid | input | 1 | Input block is valid |
| blkReady | output | 1 | Block will be accepted this cycle if valid |
| blkData | input | 513 | Transcoded block, bit 512 sent first |
| coreHdr | input | 32 | Word placed in row 0 |
| payHdr | input | 32 | Word placed in row 1 |
| rowValid | output | 1 | A row is presented this cycle |
| rowSof | output | 1 | The presented row is row 0 |
| rowIdx | output | 12 | Index of the presented row |
| rowData | output | 32 | Row contents, first bit in bit 31 |

## Verification
Two things can fall in the same cycle: the eighth block of a superblock and the tail field are appended together, and the block lands directly after up to 31 leftover bits. This happens under three input patterns: input held always valid, valid at random, and short bursts with long gaps. The last pattern leaves the buffer at varied fill levels when the eighth block arrives.

A behavioural bit-queue model in the bench predicts every row's contents, every cycle's `blkReady`, and whether a row follows on the next cycle. The rows straddling each superblock end must therefore show the block's last bits, the 24 tail bits and the next superblock's first bits in exactly that order. A second coincidence is the closing zero row followed at once by the next frame's core header. It is judged through the index, start-of-frame and header contents over three consecutive frames.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_CORE,
    SRC_PAYH,
    SRC_BUF
  } rowSrc_e;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_PAY,
    ST_PAD
  } frameSt_e;

  typedef struct packed {
    logic    emit;
    rowSrc_e src;
    logic    push;
    logic    pushTail;
  } dpStrobe_t;

endpackage

// File: rtl/sgf_frame_ctrl.sv
module sgf_frame_ctrl
  import sgf_pkg::*;
#(
  parameter int FRAME_ROWS     = 2200,
  parameter int HDR_ROWS       = 6,
  parameter int PAY_ROWS       = 2193,
  parameter int BLKS_PER_SB    = 8,
  parameter int BLKS_PER_FRAME = 136,
  parameter int IDX_W          = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic             haveRow,
  output logic             blkReady,
  output dpStrobe_t        strobe,
  output logic             rowValid,
  output logic             rowSof,
  output logic [IDX_W-1:0] rowIdx
);

  localparam int BCNT_W   = $clog2(BLKS_PER_FRAME + 1);
  localparam int SBB_W    = $clog2(BLKS_PER_SB + 1);
  localparam int PAD_ROWS = FRAME_ROWS - HDR_ROWS - PAY_ROWS;
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(FRAME_ROWS - 1);
  localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_ROWS - 1);
  localparam logic [IDX_W-1:0] LAST_PAY = IDX_W'(HDR_ROWS + PAY_ROWS - 1);
  localparam logic [BCNT_W-1:0] BLK_LIMIT = BCNT_W'(BLKS_PER_FRAME);
  localparam logic [SBB_W-1:0] SB_LAST = SBB_W'(BLKS_PER_SB - 1);

  frameSt_e         state;
  logic [IDX_W-1:0] rowCnt;
  logic [BCNT_W-1:0] blkCnt;
  logic [SBB_W-1:0] sbBlk;
  logic             rowValidQ;
  logic             rowSofQ;
  logic [IDX_W-1:0] rowIdxQ;

  always_comb begin
    strobe.emit = (state != ST_PAY) || haveRow;
    unique case (state)
      ST_HDR:  strobe.src = (rowCnt == '0) ? SRC_CORE :
                            (rowCnt == IDX_W'(1)) ? SRC_PAYH : SRC_ZERO;
      ST_PAY:  strobe.src = SRC_BUF;
      default: strobe.src = SRC_ZERO;
    endcase
    blkReady        = (state == ST_PAY) && !haveRow && (blkCnt != BLK_LIMIT);
    strobe.push     = blkValid && blkReady;
    strobe.pushTail = strobe.push && (sbBlk == SB_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HDR;
      rowCnt    <= '0;
      blkCnt    <= '0;
      sbBlk     <= '0;
      rowValidQ <= 1'b0;
      rowSofQ   <= 1'b0;
      rowIdxQ   <= '0;
    end else begin
      rowValidQ <= strobe.emit;
      rowSofQ   <= strobe.emit && (state == ST_HDR) && (rowCnt == '0);
      if (strobe.emit) begin
        rowIdxQ <= rowCnt;
        rowCnt  <= (rowCnt == LAST_ROW) ? '0 : rowCnt + IDX_W'(1);
        unique case (state)
          ST_HDR: if (rowCnt == LAST_HDR) state <= ST_PAY;
          ST_PAY: if (rowCnt == LAST_PAY) begin
            if (PAD_ROWS == 0) begin
              state  <= ST_HDR;
              blkCnt <= '0;
            end else begin
              state <= ST_PAD;
            end
          end
          default: if (rowCnt == LAST_ROW) begin
            state  <= ST_HDR;
            blkCnt <= '0;
          end
        endcase
      end
      if (strobe.push) begin
        blkCnt <= blkCnt + BCNT_W'(1);
        sbBlk  <= strobe.pushTail ? '0 : sbBlk + SBB_W'(1);
      end
    end
  end

  assign rowValid = rowValidQ;
  assign rowSof   = rowSofQ;
  assign rowIdx   = rowIdxQ;

endmodule

// File: rtl/sgf_row_datapath.sv
module sgf_row_datapath
  import sgf_pkg::*;
#(
  parameter int          BLK_W      = 513,
  parameter int          ROW_W      = 32,
  parameter int          TAIL_W     = 24,
  parameter logic [63:0] TAIL_FIELD = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BLK_W-1:0] blkData,
  input  logic [ROW_W-1:0] coreHdr,
  input  logic [ROW_W-1:0] payHdr,
  output logic             haveRow,
  output logic [ROW_W-1:0] rowData
);

  localparam int BUF_W = BLK_W + TAIL_W + ROW_W - 1;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] bufQ;
  logic [CNT_W-1:0] cntQ;
  logic [BUF_W-1:0] tailVec;
  logic [BUF_W-1:0] alignedIn;
  logic [ROW_W-1:0] rowDataQ;
  logic [CNT_W-1:0] addBits;

  generate
    if (TAIL_W > 0) begin : g_tail
      logic [TAIL_W-1:0] tailBits;
      assign tailBits = TAIL_FIELD[TAIL_W-1:0];
      assign tailVec  = strobe.pushTail ?
                        (BUF_W'(tailBits) << (BUF_W - BLK_W - TAIL_W)) : '0;
      assign addBits  = CNT_W'(BLK_W) + (strobe.pushTail ? CNT_W'(TAIL_W) : '0);
    end else begin : g_noTail
      assign tailVec = '0;
      assign addBits = CNT_W'(BLK_W);
    end
  endgenerate

  assign alignedIn = ((BUF_W'(blkData) << (BUF_W - BLK_W)) | tailVec) >> cntQ;
  assign haveRow   = cntQ >= CNT_W'(ROW_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ     <= '0;
      cntQ     <= '0;
      rowDataQ <= '0;
    end else begin
      if (strobe.emit && strobe.src == SRC_BUF) begin
        bufQ <= bufQ << ROW_W;
        cntQ <= cntQ - CNT_W'(ROW_W);
      end else if (strobe.push) begin
        bufQ <= bufQ | alignedIn;
        cntQ <= cntQ + addBits;
      end
      if (strobe.emit) begin
        unique case (strobe.src)
          SRC_CORE: rowDataQ <= coreHdr;
          SRC_PAYH: rowDataQ <= payHdr;
          SRC_BUF:  rowDataQ <= bufQ[BUF_W-1 -: ROW_W];
          default:  rowDataQ <= '0;
        endcase
      end
    end
  end

  assign rowData = rowDataQ;

endmodule

// File: rtl/sgf_superblock_framer.sv
module sgf_superblock_framer
  import sgf_pkg::*;
#(
  parameter int          BLK_W        = 513,
  parameter int          BLKS_PER_SB  = 8,
  parameter int          SB_OCTETS    = 516,
  parameter int          SB_PER_FRAME = 17,
  parameter int          ROW_W        = 32,
  parameter int          HDR_ROWS     = 6,
  parameter int          FRAME_ROWS   = 2200,
  parameter logic [63:0] TAIL_FIELD   = '0,
  localparam int         IDX_W        = $clog2(FRAME_ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  output logic             blkReady,
  input  logic [BLK_W-1:0] blkData,
  input  logic [ROW_W-1:0] coreHdr,
  input  logic [ROW_W-1:0] payHdr,
  output logic             rowValid,
  output logic             rowSof,
  output logic [IDX_W-1:0] rowIdx,
  output logic [ROW_W-1:0] rowData
);

  localparam int SB_BITS     = SB_OCTETS * 8;
  localparam int TAIL_W      = SB_BITS - BLKS_PER_SB * BLK_W;
  localparam int ROWS_PER_SB = SB_BITS / ROW_W;
  localparam int PAY_ROWS    = ROWS_PER_SB * SB_PER_FRAME;

  dpStrobe_t strobe;
  logic      haveRow;

  sgf_frame_ctrl #(
    .FRAME_ROWS    (FRAME_ROWS),
    .HDR_ROWS      (HDR_ROWS),
    .PAY_ROWS      (PAY_ROWS),
    .BLKS_PER_SB   (BLKS_PER_SB),
    .BLKS_PER_FRAME(BLKS_PER_SB * SB_PER_FRAME),
    .IDX_W         (IDX_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .blkValid(blkValid),
    .haveRow (haveRow),
    .blkReady(blkReady),
    .strobe  (strobe),
    .rowValid(rowValid),
    .rowSof  (rowSof),
    .rowIdx  (rowIdx)
  );

  sgf_row_datapath #(
    .BLK_W     (BLK_W),
    .ROW_W     (ROW_W),
    .TAIL_W    (TAIL_W),
    .TAIL_FIELD(TAIL_FIELD)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .blkData(blkData),
    .coreHdr(coreHdr),
    .payHdr (payHdr),
    .haveRow(haveRow),
    .rowData(rowData)
  );

endmodule

// File: rtl/sgf_framer_checker.sv
module sgf_framer_checker #(
  parameter int FRAME_ROWS = 2200,
  parameter int HDR_ROWS   = 6,
  parameter int ROW_W      = 32,
  parameter int IDX_W      = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             blkReady,
  input logic             rowValid,
  input logic             rowSof,
  input logic [IDX_W-1:0] rowIdx,
  input logic [ROW_W-1:0] rowData
);

  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(FRAME_ROWS - 1);

  logic             seenRow;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] wantIdx;

  assign wantIdx = (lastIdx == LAST_ROW) ? '0 : lastIdx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRow <= 1'b0;
      lastIdx <= '0;
    end else if (rowValid) begin
      seenRow <= 1'b1;
      lastIdx <= rowIdx;
    end
  end

  AST_INDEX_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN) rowValid && seenRow |-> rowIdx == wantIdx); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN) rowValid && rowIdx == LAST_ROW |=> rowValid && rowIdx == '0); // R1
  AST_SOF_ONLY_ROW0: assert property (@(posedge clk) disable iff (!rstN) rowSof |-> rowValid && rowIdx == '0); // R2
  AST_ROW0_MARKED: assert property (@(posedge clk) disable iff (!rstN) rowValid && rowIdx == '0 |-> rowSof); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN) rowValid && rowIdx >= IDX_W'(2) && rowIdx < IDX_W'(HDR_ROWS) |-> rowData == '0); // R4
  AST_CLOSING_ZERO: assert property (@(posedge clk) disable iff (!rstN) rowValid && rowIdx == LAST_ROW |-> rowData == '0); // R6
  AST_NO_READY_IN_HDR: assert property (@(posedge clk) disable iff (!rstN) rowValid && rowIdx < IDX_W'(HDR_ROWS - 1) |-> !blkReady); // R7
  AST_READY_NO_ROW: assert property (@(posedge clk) disable iff (!rstN) blkReady |=> !rowValid); // R8

endmodule

bind sgf_superblock_framer sgf_framer_checker #(
  .FRAME_ROWS(FRAME_ROWS),
  .HDR_ROWS  (HDR_ROWS),
  .ROW_W     (ROW_W),
  .IDX_W     (IDX_W)
) i_sgf_framer_checker (
  .clk     (clk),
  .rstN    (rstN),
  .blkReady(blkReady),
  .rowValid(rowValid),
  .rowSof  (rowSof),
  .rowIdx  (rowIdx),
  .rowData (rowData)
);

// File: tb/test_sgf_superblock_framer.sv
module test_sgf_superblock_framer;

  localparam int          BLK_W      = 513;
  localparam int          TAIL_W     = 24;
  localparam int          FRAME_ROWS = 2200;
  localparam int          PAY_FIRST  = 6;
  localparam int          PAY_LAST   = 2198;
  localparam int          FRAME_BLKS = 136;
  localparam logic [63:0] TAIL_VAL   = 64'h0000_0000_00A5_C3E1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             blkValid = 1'b0;
  logic             blkReady;
  logic [BLK_W-1:0] blkData = '0;
  logic [31:0]      coreHdr = 32'hC0DE_0001;
  logic [31:0]      payHdr = 32'hFACE_0001;
  logic             rowValid;
  logic             rowSof;
  logic [11:0]      rowIdx;
  logic [31:0]      rowData;

  always #4 clk = ~clk;

  sgf_superblock_framer #(.TAIL_FIELD(TAIL_VAL)) i_sgf_superblock_framer (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkReady(blkReady),
    .blkData(blkData), .coreHdr(coreHdr), .payHdr(payHdr),
    .rowValid(rowValid), .rowSof(rowSof), .rowIdx(rowIdx), .rowData(rowData)
  );

  int checks = 0;
  int errors = 0;
  bit bq[$];
  int nextRow = 0;
  int blkFrame = 0;
  int blkIdx = 0;
  int framesDone = 0;
  int cyc = 0;
  logic expValidNext = 1'b0;
  logic [31:0] coreCur = 32'hC0DE_0001;
  logic [31:0] payCur = 32'hFACE_0001;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BLK_W-1:0] mkBlk(input int n);
    logic [575:0] v;
    for (int i = 0; i < 18; i++)
      v[i*32 +: 32] = (32'(n) * 32'h9E37_79B1) ^ (32'(i + 1) * 32'h85EB_CA6B) ^ 32'(n << 7);
    return v[BLK_W-1:0];
  endfunction

  function automatic bit inPay(input int r);
    return (r >= PAY_FIRST) && (r <= PAY_LAST);
  endfunction

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check("R9", "rowValid in reset", rowValid, 0);
      check("R9", "rowSof in reset", rowSof, 0);
      check("R9", "blkReady in reset", blkReady, 0);
    end
    rstN = 1'b1;
    expValidNext = 1'b1;
    while (framesDone < 3 && cyc < 150000) begin
      logic [31:0] expRow;
      logic        expReady;
      @(negedge clk);
      cyc++;
      check("R8", "row emitted when due", rowValid, expValidNext);
      if (rowValid) begin
        check("R1", "row index order", rowIdx, nextRow);
        check("R2", "sof on row 0 only", rowSof, nextRow == 0);
        if (nextRow == 0) check("R3", "core header row", rowData, coreCur);
        else if (nextRow == 1) check("R3", "payload header row", rowData, payCur);
        else if (nextRow < PAY_FIRST) check("R4", "reserved row zero", rowData, 0);
        else if (nextRow == FRAME_ROWS - 1) check("R6", "closing row zero", rowData, 0);
        else begin
          if (bq.size() < 32) begin
            errors++;
            $display("FAIL R5 payload row %0d without 32 model bits: actual %0h expected none", nextRow, rowData);
          end else begin
            for (int b = 31; b >= 0; b--) expRow[b] = bq.pop_front();
            check("R5", "superblock payload bits", rowData, expRow);
          end
        end
        if (nextRow == FRAME_ROWS - 1) begin
          blkFrame = 0;
          framesDone++;
        end
        nextRow = (nextRow + 1) % FRAME_ROWS;
      end else begin
        check("R2", "sof low without row", rowSof, 0);
      end
      expReady = inPay(nextRow) && bq.size() < 32 && blkFrame < FRAME_BLKS;
      check("R7", "ready condition", blkReady, expReady);
      expValidNext = !inPay(nextRow) || bq.size() >= 32;
      if (nextRow == 1000) begin
        coreCur = coreCur + 32'h0101_0101;
        payCur  = payCur ^ 32'h00F0_F00F;
        coreHdr = coreCur;
        payHdr  = payCur;
      end
      case (framesDone)
        0:       blkValid = 1'b1;
        1:       blkValid = 1'($urandom % 2);
        default: blkValid = (cyc % 40) < 5;
      endcase
      blkData = mkBlk(blkIdx);
      if (blkValid && blkReady) begin
        for (int b = BLK_W - 1; b >= 0; b--) bq.push_back(blkData[b]);
        blkIdx++;
        blkFrame++;
        if (blkFrame % 8 == 0)
          for (int b = TAIL_W - 1; b >= 0; b--) bq.push_back(TAIL_VAL[b]);
      end
    end
    if (framesDone < 3) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d frames expected 3", framesDone);
    end
    check("R5", "model queue drained at frame end", bq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule